// File: doc/BRIEF.md
# Word-Serial Commitment-Challenge-Response Sequencer

This block carries out the tag side of a commitment-challenge-response exchange in four fixed steps. After a start request it sends a stored commitment on its transmit stream. It then collects the reader's challenge from a receive stream and passes the challenge to an external multiplier. Finally it forms the response y = r + s·c as a plain integer sum and transmits it. No modular reduction is applied. The secret product s·c and the pseudo-random value r both come from outside, over valid/ready ports. The product arrives as 32-bit words. The random value arrives as 64-bit keystream blocks.

The response is built one 32-bit word at a time, least significant word first. A one-bit carry links each word to the next. The product is 196 bits long. The random value, and therefore the response, is 80 bits longer at 276 bits. Once the product words run out, the upper random words receive only the carry. The whole product and the whole random value are never held: each word is summed as soon as its operands are present, then sent.

Top module: `cr_resp_sequencer`

## Requirements
- R1: After `start_i` the commitment goes out first. It is sent as COMMIT_W/32 words, lowest word first, with `tx_resp_o`=0 and `tx_last_o`=1 on its final word. `rx_ready_o` stays 0 until that final commitment word has been accepted, and while `rx_ready_o` is 1 no transmit word is pending.
- R2: The challenge is taken as ceil(CHAL_W/32) receive words, lowest word first. Bits above CHAL_W are ignored. One cycle after the last challenge word is accepted, `mul_start_o` pulses for exactly one cycle, and `chal_o` then holds the challenge.
- R3: Response word k (k = 0..8) equals bits [32k+31:32k] of (r[275:0] + p[195:0]) taken modulo 2^276. The words are sent in rising k order with `tx_resp_o`=1, and `tx_last_o`=1 only on word 8.
- R4: The carry is cleared at the start of every response, so a carry out of one exchange never reaches the next.
- R5: The random value is taken as exactly 5 blocks per response. Each block is used low 32-bit half first. The high half of the fifth block is ignored. `r_ready_o` is 0 outside the response step.
- R6: The product is taken as exactly 7 words per response. Words 7 and 8 add only the carry to the random word. `p_ready_o` is 0 outside the response step.
- R7: The final response word carries 20 valid bits, and its bits [31:20] are zero.
- R8: While `tx_valid_o`=1 and `tx_ready_i`=0, the transmit word, its last flag and its valid stay unchanged.
- R9: `start_i` has no effect while an exchange is in progress. After the final response word is accepted, the block sends nothing and requests nothing until the next start.
- R10: In reset and straight after it, `tx_valid_o`, `rx_ready_o`, `r_ready_o`, `p_ready_o` and `mul_start_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an exchange (sampled when idle) |
| commit_i | input | COMMIT_W | Stored commitment value |
| rx_data_i | input | WORD_W | Challenge word from the reader |
| rx_valid_i | input | 1 | Challenge word valid |
| rx_ready_o | output | 1 | Challenge word accepted |
| chal_o | output | CHAL_W | Collected challenge for the multiplier |
| mul_start_o | output | 1 | One-cycle pulse: challenge complete |
| r_data_i | input | BLOCK_W | Keystream block of the random value |
| r_valid_i | input | 1 | Keystream block valid |
| r_ready_o | output | 1 | Keystream block accepted |
| p_data_i | input | WORD_W | Product word, lowest first |
| p_valid_i | input | 1 | Product word valid |
| p_ready_o | output | 1 | Product word accepted |
| tx_data_o | output | WORD_W | Transmit word (commitment or response) |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_ready_i | input | 1 | Transmit word accepted |
| tx_last_o | output | 1 | Final word of the current message |
| tx_resp_o | output | 1 | 1 for response words, 0 for commitment words |

## Verification
The assertions assume the sources keep a valid asserted until it is accepted. They also assume the multiplier zero-fills the bits of its top word above the 196-bit product, so the masked final word and the carry counts stay meaningful. The stimulus keeps to this contract. Once a valid is raised, its data is held until a handshake fires, and the product is built as a 196-bit value with its pad bits zero. Random stalls on every port, a carry chain that runs through all of the upper random words, and start requests held high during the exchange all stay within these assumptions.

// File: rtl/cr_resp_pkg.sv
package cr_resp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COMMIT = 2'd1,
        PH_CHAL   = 2'd2,
        PH_RESP   = 2'd3
    } phase_e;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cr_word_adder.sv
module cr_word_adder #(
    parameter int WORD_W    = 32,
    parameter int LAST_BITS = 20
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              trunc_i,
    output logic [WORD_W-1:0] sum_o,
    output logic              cout_o
);
    localparam logic [WORD_W-1:0] TOP_MASK = {WORD_W{1'b1}} >> (WORD_W - LAST_BITS);

    logic [WORD_W:0] raw;

    always_comb begin
        raw    = {1'b0, a_i} + {1'b0, b_i} + {{WORD_W{1'b0}}, cin_i};
        cout_o = raw[WORD_W];
        sum_o  = trunc_i ? (raw[WORD_W-1:0] & TOP_MASK) : raw[WORD_W-1:0];
    end
endmodule

// File: rtl/cr_rblock_buf.sv
module cr_rblock_buf #(
    parameter int WORD_W   = 32,
    parameter int BLOCK_W  = 64,
    parameter int N_BLOCKS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               clear_i,
    input  logic [BLOCK_W-1:0] in_data_i,
    input  logic               in_valid_i,
    output logic               in_ready_o,
    output logic [WORD_W-1:0]  word_o,
    output logic               word_valid_o,
    input  logic               pop_i,
    input  logic               flush_i
);
    localparam int HALVES = BLOCK_W / WORD_W;
    localparam int SW     = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam int TW     = $clog2(N_BLOCKS + 1);
    localparam logic [SW-1:0] SEL_LAST = SW'(HALVES - 1);
    localparam logic [TW-1:0] TAKE_MAX = TW'(N_BLOCKS);

    typedef struct packed {
        logic [BLOCK_W-1:0] data;
        logic               full;
        logic [SW-1:0]      sel;
        logic [TW-1:0]      taken;
    } buf_t;

    buf_t q, d;
    logic               in_fire;
    logic [BLOCK_W-1:0] shifted;

    always_comb begin
        d          = q;
        in_ready_o = en_i && !q.full && (q.taken < TAKE_MAX);
        in_fire    = in_ready_o && in_valid_i;
        shifted    = q.data >> (WORD_W * q.sel);
        word_o       = shifted[WORD_W-1:0];
        word_valid_o = q.full;

        if (clear_i) begin
            d.full  = 1'b0;
            d.sel   = '0;
            d.taken = '0;
        end else if (in_fire) begin
            d.data  = in_data_i;
            d.full  = 1'b1;
            d.sel   = '0;
            d.taken = q.taken + TW'(1);
        end else if (pop_i && q.full) begin
            if (flush_i || q.sel == SEL_LAST) begin
                d.full = 1'b0;
                d.sel  = '0;
            end else begin
                d.sel = q.sel + SW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cr_chal_collect.sv
module cr_chal_collect #(
    parameter int WORD_W = 32,
    parameter int CHAL_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [WORD_W-1:0] rx_data_i,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    output logic [CHAL_W-1:0] chal_o,
    output logic              done_o
);
    localparam int CHAL_WORDS = (CHAL_W + WORD_W - 1) / WORD_W;
    localparam int CHAL_PAD   = CHAL_WORDS * WORD_W;
    localparam int IW         = (CHAL_WORDS > 1) ? $clog2(CHAL_WORDS) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(CHAL_WORDS - 1);

    typedef struct packed {
        logic [CHAL_W-1:0] chal;
        logic [IW-1:0]     idx;
    } col_t;

    col_t q, d;
    logic                fire;
    logic [CHAL_PAD-1:0] padded;

    always_comb begin
        d          = q;
        rx_ready_o = en_i;
        fire       = en_i && rx_valid_i;
        done_o     = fire && (q.idx == IDX_LAST);
        padded     = CHAL_PAD'(q.chal);
        for (int k = 0; k < CHAL_WORDS; k++) begin
            if (fire && q.idx == IW'(k)) padded[k*WORD_W +: WORD_W] = rx_data_i;
        end
        if (fire) begin
            d.chal = padded[CHAL_W-1:0];
            d.idx  = done_o ? '0 : q.idx + IW'(1);
        end
        chal_o = q.chal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cr_resp_sequencer.sv
module cr_resp_sequencer
    import cr_resp_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BLOCK_W   = 64,
    parameter int PROD_W    = 196,
    parameter int SURPLUS_W = 80,
    parameter int COMMIT_W  = 64,
    parameter int CHAL_W    = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [COMMIT_W-1:0] commit_i,
    input  logic [WORD_W-1:0]   rx_data_i,
    input  logic                rx_valid_i,
    output logic                rx_ready_o,
    output logic [CHAL_W-1:0]   chal_o,
    output logic                mul_start_o,
    input  logic [BLOCK_W-1:0]  r_data_i,
    input  logic                r_valid_i,
    output logic                r_ready_o,
    input  logic [WORD_W-1:0]   p_data_i,
    input  logic                p_valid_i,
    output logic                p_ready_o,
    output logic [WORD_W-1:0]   tx_data_o,
    output logic                tx_valid_o,
    input  logic                tx_ready_i,
    output logic                tx_last_o,
    output logic                tx_resp_o
);
    localparam int RESP_W       = PROD_W + SURPLUS_W;
    localparam int RESP_WORDS   = cdiv(RESP_W, WORD_W);
    localparam int PROD_WORDS   = cdiv(PROD_W, WORD_W);
    localparam int HALVES       = BLOCK_W / WORD_W;
    localparam int R_BLOCKS     = cdiv(RESP_WORDS, HALVES);
    localparam int COMMIT_WORDS = cdiv(COMMIT_W, WORD_W);
    localparam int COMMIT_PAD   = COMMIT_WORDS * WORD_W;
    localparam int LAST_BITS    = RESP_W - (RESP_WORDS - 1) * WORD_W;
    localparam int CW           = $clog2(imax(COMMIT_WORDS, RESP_WORDS) + 1);

    localparam logic [CW-1:0] CNT_COMMIT    = CW'(COMMIT_WORDS);
    localparam logic [CW-1:0] CNT_COMMIT_LS = CW'(COMMIT_WORDS - 1);
    localparam logic [CW-1:0] CNT_RESP      = CW'(RESP_WORDS);
    localparam logic [CW-1:0] CNT_RESP_LS   = CW'(RESP_WORDS - 1);
    localparam logic [CW-1:0] CNT_PROD      = CW'(PROD_WORDS);

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic              carry;
        logic              out_v;
        logic [WORD_W-1:0] out_data;
        logic              out_last;
        logic              out_resp;
        logic              mstart;
    } seq_t;

    seq_t q, d;

    // handshake and datapath nets between the sequencer and its helpers
    logic              chal_en, chal_done;
    logic              r_en, r_clear, r_pop, r_flush;
    logic [WORD_W-1:0] r_word;
    logic              r_word_v;
    logic [WORD_W-1:0] add_b, add_sum;
    logic              add_trunc, add_cout;
    logic              slot_free, tx_fire, in_prod, can_load, go;
    logic [COMMIT_PAD-1:0] commit_ext, commit_sh;

    cr_chal_collect #(.WORD_W(WORD_W), .CHAL_W(CHAL_W)) u_chal (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (chal_en),
        .rx_data_i  (rx_data_i),
        .rx_valid_i (rx_valid_i),
        .rx_ready_o (rx_ready_o),
        .chal_o     (chal_o),
        .done_o     (chal_done)
    );

    cr_rblock_buf #(.WORD_W(WORD_W), .BLOCK_W(BLOCK_W), .N_BLOCKS(R_BLOCKS)) u_rbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (r_en),
        .clear_i      (r_clear),
        .in_data_i    (r_data_i),
        .in_valid_i   (r_valid_i),
        .in_ready_o   (r_ready_o),
        .word_o       (r_word),
        .word_valid_o (r_word_v),
        .pop_i        (r_pop),
        .flush_i      (r_flush)
    );

    cr_word_adder #(.WORD_W(WORD_W), .LAST_BITS(LAST_BITS)) u_add (
        .a_i     (r_word),
        .b_i     (add_b),
        .cin_i   (q.carry),
        .trunc_i (add_trunc),
        .sum_o   (add_sum),
        .cout_o  (add_cout)
    );

    always_comb begin
        d          = q;
        d.mstart   = 1'b0;
        slot_free  = !q.out_v || tx_ready_i;
        tx_fire    = q.out_v && tx_ready_i;
        if (tx_fire) d.out_v = 1'b0;

        commit_ext = COMMIT_PAD'(commit_i);
        commit_sh  = commit_ext >> (WORD_W * q.cnt);

        chal_en   = (q.phase == PH_CHAL);
        r_en      = (q.phase == PH_RESP);
        r_clear   = chal_done;
        in_prod   = (q.cnt < CNT_PROD);
        add_b     = in_prod ? p_data_i : '0;
        add_trunc = (q.cnt == CNT_RESP_LS);
        can_load  = r_en && slot_free && r_word_v && (q.cnt < CNT_RESP);
        p_ready_o = can_load && in_prod;
        go        = can_load && (!in_prod || p_valid_i);
        r_pop     = go;
        r_flush   = go && (q.cnt == CNT_RESP_LS);

        unique case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.phase = PH_COMMIT;
                    d.cnt   = '0;
                end
            end
            PH_COMMIT: begin
                if (slot_free && q.cnt < CNT_COMMIT) begin
                    d.out_v    = 1'b1;
                    d.out_data = commit_sh[WORD_W-1:0];
                    d.out_last = (q.cnt == CNT_COMMIT_LS);
                    d.out_resp = 1'b0;
                    d.cnt      = q.cnt + CW'(1);
                end
                if (tx_fire && q.out_last) d.phase = PH_CHAL;
            end
            PH_CHAL: begin
                if (chal_done) begin
                    d.phase  = PH_RESP;
                    d.cnt    = '0;
                    d.carry  = 1'b0;
                    d.mstart = 1'b1;
                end
            end
            PH_RESP: begin
                if (go) begin
                    d.out_v    = 1'b1;
                    d.out_data = add_sum;
                    d.out_last = (q.cnt == CNT_RESP_LS);
                    d.out_resp = 1'b1;
                    d.carry    = add_cout;
                    d.cnt      = q.cnt + CW'(1);
                end
                if (tx_fire && q.out_last) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase

        tx_data_o   = q.out_data;
        tx_valid_o  = q.out_v;
        tx_last_o   = q.out_last;
        tx_resp_o   = q.out_resp;
        mul_start_o = q.mstart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cr_resp_sequencer_chk.sv
module cr_resp_sequencer_chk
    import cr_resp_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BLOCK_W   = 64,
    parameter int PROD_W    = 196,
    parameter int SURPLUS_W = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] tx_data_o,
    input logic              tx_valid_o,
    input logic              tx_ready_i,
    input logic              tx_last_o,
    input logic              tx_resp_o,
    input logic              rx_ready_o,
    input logic              r_valid_i,
    input logic              r_ready_o,
    input logic              p_valid_i,
    input logic              p_ready_o,
    input logic              mul_start_o
);
    localparam int RESP_W     = PROD_W + SURPLUS_W;
    localparam int RESP_WORDS = cdiv(RESP_W, WORD_W);
    localparam int PROD_WORDS = cdiv(PROD_W, WORD_W);
    localparam int R_BLOCKS   = cdiv(RESP_WORDS, BLOCK_W / WORD_W);
    localparam int LAST_BITS  = RESP_W - (RESP_WORDS - 1) * WORD_W;
    localparam logic [WORD_W-1:0] HIGH_BITS = ~({WORD_W{1'b1}} >> (WORD_W - LAST_BITS));

    int unsigned r_taken_q, p_taken_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_taken_q <= 0;
            p_taken_q <= 0;
        end else if (mul_start_o) begin
            r_taken_q <= 0;
            p_taken_q <= 0;
        end else begin
            if (r_valid_i && r_ready_o) r_taken_q <= r_taken_q + 1;
            if (p_valid_i && p_ready_o) p_taken_q <= p_taken_q + 1;
        end
    end

    p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

    p_last_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && tx_resp_o && tx_last_o |-> (tx_data_o & HIGH_BITS) == '0);

    p_chal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready_o |-> !tx_valid_o);

    p_phase_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready_o |-> !r_ready_o && !p_ready_o);

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start_o |=> !mul_start_o);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_taken_q <= R_BLOCKS);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        p_taken_q <= PROD_WORDS);
endmodule

bind cr_resp_sequencer cr_resp_sequencer_chk #(
    .WORD_W(WORD_W), .BLOCK_W(BLOCK_W), .PROD_W(PROD_W), .SURPLUS_W(SURPLUS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_last_o   (tx_last_o),
    .tx_resp_o   (tx_resp_o),
    .rx_ready_o  (rx_ready_o),
    .r_valid_i   (r_valid_i),
    .r_ready_o   (r_ready_o),
    .p_valid_i   (p_valid_i),
    .p_ready_o   (p_ready_o),
    .mul_start_o (mul_start_o)
);

// File: tb/cr_resp_sequencer_tb.sv
module cr_resp_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W      = 32;
    localparam int RBITS  = 276;
    localparam int NRESP  = 9;
    localparam int NPROD  = 7;
    localparam int NBLK   = 5;
    localparam int NCOM   = 2;
    localparam int NCHAL  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [63:0]   commit_i = '0;
    logic [W-1:0]  rx_data_i = '0;
    logic          rx_valid_i = 1'b0;
    logic          rx_ready_o;
    logic [35:0]   chal_o;
    logic          mul_start_o;
    logic [63:0]   r_data_i = '0;
    logic          r_valid_i = 1'b0;
    logic          r_ready_o;
    logic [W-1:0]  p_data_i = '0;
    logic          p_valid_i = 1'b0;
    logic          p_ready_o;
    logic [W-1:0]  tx_data_o;
    logic          tx_valid_o;
    logic          tx_ready_i = 1'b0;
    logic          tx_last_o;
    logic          tx_resp_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cr_resp_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .commit_i(commit_i),
        .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o),
        .chal_o(chal_o), .mul_start_o(mul_start_o),
        .r_data_i(r_data_i), .r_valid_i(r_valid_i), .r_ready_o(r_ready_o),
        .p_data_i(p_data_i), .p_valid_i(p_valid_i), .p_ready_o(p_ready_o),
        .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .tx_last_o(tx_last_o), .tx_resp_o(tx_resp_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [319:0] rnd320();
        logic [319:0] v;
        for (int i = 0; i < 10; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // One full exchange against a queue-based reference model.
    task automatic run_exchange(input logic [319:0] rv, input logic [195:0] pv,
                                input logic [63:0] cv, input logic [63:0] cm,
                                input bit stall, input bit poke, input string tag);
        logic [33:0]  exp_q[$];
        logic [275:0] sum;
        logic [287:0] sum_ext;
        logic [223:0] pext;
        int ri = 0, pi = 0, ci = 0, com_acc = 0, mst = 0, cyc = 0;
        bit rf, pf, cf, tf;
        sum     = rv[275:0] + 276'(pv);
        sum_ext = 288'(sum);
        pext    = 224'(pv);
        for (int k = 0; k < NCOM; k++) exp_q.push_back({1'b0, (k == NCOM-1), cm[k*32 +: 32]});
        for (int k = 0; k < NRESP; k++) exp_q.push_back({1'b1, (k == NRESP-1), sum_ext[k*32 +: 32]});
        commit_i = cm;
        rf = 0; pf = 0; cf = 0;
        while (exp_q.size() != 0 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            start_i = (cyc == 1) || (poke && cyc > 2);
            if (!(r_valid_i && !rf)) begin
                r_valid_i = (ri < NBLK) && (!stall || ($urandom % 10) < 6);
                r_data_i  = (ri < NBLK) ? rv[ri*64 +: 64] : '0;
            end
            if (!(p_valid_i && !pf)) begin
                p_valid_i = (pi < NPROD) && (!stall || ($urandom % 10) < 6);
                p_data_i  = (pi < NPROD) ? pext[pi*32 +: 32] : '0;
            end
            if (!(rx_valid_i && !cf)) begin
                rx_valid_i = (ci < NCHAL) && (!stall || ($urandom % 10) < 6);
                rx_data_i  = (ci < NCHAL) ? cv[ci*32 +: 32] : '0;
            end
            tx_ready_i = !stall || ($urandom % 10) < 6;
            #1;
            rf = r_valid_i && r_ready_o;
            pf = p_valid_i && p_ready_o;
            cf = rx_valid_i && rx_ready_o;
            tf = tx_valid_o && tx_ready_i;
            if (rf) ri++;
            if (pf) pi++;
            if (cf) begin
                // R1: no challenge accepted before the commitment has gone out
                check(com_acc == NCOM, "R1 challenge order", 64'(com_acc), 64'(NCOM));
                ci++;
            end
            if (mul_start_o) begin
                mst++;
                check(chal_o == cv[35:0], "R2 challenge value", 64'(chal_o), 64'(cv[35:0]));
            end
            if (tf) begin
                if (!tx_resp_o) com_acc++;
                check({tx_resp_o, tx_last_o, tx_data_o} == exp_q[0],
                      exp_q[0][33] ? tag : "R1 commitment word",
                      64'({tx_resp_o, tx_last_o, tx_data_o}), 64'(exp_q[0]));
                if (tx_resp_o && tx_last_o)
                    check(tx_data_o[31:20] == 12'h0, "R7 final word pad", 64'(tx_data_o[31:20]), 64'h0);
                void'(exp_q.pop_front());
            end
        end
        check(cyc < 3000, "watchdog exchange", 64'(cyc), 64'(3000));
        @(negedge clk);
        start_i = 0; r_valid_i = 0; p_valid_i = 0; rx_valid_i = 0; tx_ready_i = 1;
        check(ri == NBLK, "R5 block count", 64'(ri), 64'(NBLK));
        check(pi == NPROD, "R6 product count", 64'(pi), 64'(NPROD));
        check(mst == 1, "R2 start pulse count", 64'(mst), 64'h1);
        // R9: after completion the block stays quiet until a new start
        r_valid_i = 1; p_valid_i = 1; rx_valid_i = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            #1;
            check(!tx_valid_o && !rx_ready_o && !r_ready_o && !p_ready_o, "R9 idle after exchange",
                  64'({tx_valid_o, rx_ready_o, r_ready_o, p_ready_o}), 64'h0);
        end
        r_valid_i = 0; p_valid_i = 0; rx_valid_i = 0;
    endtask

    initial begin
        logic [319:0] rv;
        logic [195:0] pv;
        // R10: reset state
        repeat (3) @(negedge clk);
        check({tx_valid_o, rx_ready_o, r_ready_o, p_ready_o, mul_start_o} == 5'b0,
              "R10 in reset", 64'({tx_valid_o, rx_ready_o, r_ready_o, p_ready_o, mul_start_o}), 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check({tx_valid_o, rx_ready_o, r_ready_o, p_ready_o, mul_start_o} == 5'b0,
              "R10 after reset", 64'({tx_valid_o, rx_ready_o, r_ready_o, p_ready_o, mul_start_o}), 64'h0);

        // R3: plain streams, no stalls
        rv = rnd320(); pv = 196'(rnd320());
        run_exchange(rv, pv, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 1'b0, "R3 response word");
        // R3/R8: random stalls on every port
        rv = rnd320(); pv = 196'(rnd320());
        run_exchange(rv, pv, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1, 1'b0, "R3 stalled word");
        // R6: carry ripples through all upper random words, final carry dropped
        rv = rnd320(); rv[287:192] = '1;
        pv = 196'(rnd320()); pv[192] = 1'b1;
        run_exchange(rv, pv, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1, 1'b0, "R6 carry ripple");
        // R4: next exchange must start with a cleared carry
        rv = rnd320(); pv = 196'(rnd320());
        run_exchange(rv, pv, {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 1'b0, "R4 carry cleared");
        // R9: start held high during the exchange; zero product
        rv = rnd320(); pv = '0;
        run_exchange(rv, pv, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1, 1'b1, "R9 start ignored");
        for (int n = 0; n < 4; n++) begin
            rv = rnd320(); pv = 196'(rnd320());
            run_exchange(rv, pv, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1, n[0], "R3 random word");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule